// File: doc/BRIEF.md
# Synchronous 8-bit Serial Shift Port

This block moves one byte at a time over a three-wire synchronous link: a shift clock (SCK), a serial output (SO) and a serial input (SI). A byte written into the data register goes out on SO while the byte arriving on SI fills the same register, so that at the end of a transfer the register holds the received byte. Outgoing bits change on the falling edge of the shift clock and incoming bits are captured on the rising edge.

The shift clock comes from one of two sources. Three internal rates (the system clock divided by 4, 16 or 64) make the block the clock master: it drives a 50% duty clock out through the SCK output enable. A fourth setting makes it a slave: it follows an SCK input, which passes through a two-flop synchronizer and edge detector in the system clock domain. Software sets a start bit in the mode register to launch a transfer. The start bit clears by itself after the eighth bit. A sticky completion flag then sets, and it raises an interrupt request when enabled. While a transfer runs, both registers refuse writes.

Top module: `sio8_port`

## Requirements
- R1: After reset, the mode register reads 0x00, sck_out and so are high, sck_oe is high and irq is low.
- R2: Mode bits [1:0] = 00, 01, 10 select an internal shift clock of 4, 16 or 64 system clocks per period, with equal high and low halves, and sck_oe high.
- R3: SO changes only on a falling shift-clock edge. Mode bit 2 = 1 sends data register bit 7 first, and bit 2 = 0 sends bit 0 first.
- R4: SI is sampled on each rising shift-clock edge. After eight bits, the data register (address 1) holds the received byte, with the first received bit in bit 7 (MSB-first) or in bit 0 (LSB-first).
- R5: Mode bits [1:0] = 11 select the external clock. sck_oe is then low, and one bit moves per falling/rising pair of sck_in, down to one system clock per level.
- R6: Writing mode bit 7 = 1 while idle starts a transfer. Bit 7 stays 1 until the eighth rising edge and then clears by itself, never earlier.
- R7: While bit 7 is 1, writes to the mode register (address 0) and to the data register (address 1) have no effect.
- R8: Mode bit 6 sets when a transfer completes. Writing 0 to it while idle clears it, and writing 1 to it leaves it unchanged. irq equals bit 6 AND mode bit 3.
- R9: While idle, sck_out stays high and so holds the last bit shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_addr | input | 1 | Register select: 0 mode, 1 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| sck_in | input | 1 | Shift clock from the pin (external mode) |
| sck_out | output | 1 | Shift clock driven to the pin |
| sck_oe | output | 1 | Output enable for the SCK pin |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| irq | output | 1 | Completion interrupt request |

## Verification
The hardest situation to reach is a slave transfer at the fastest allowed external clock, where every sck_in level lasts a single system clock. The synchronizer delay then shifts each detected edge by several cycles against the pin. The bench gets there by toggling sck_in every cycle with SI held constant. It checks that seven pulses leave the transfer still running and that the eighth ends it with all ones received. A second hard case is a write that arrives in the middle of a transfer. The bench issues mode and data writes between two shift edges and then confirms from the register readback and the final received byte that neither write took effect.

// File: rtl/sio8_pkg.sv
package sio8_pkg;

  localparam int DW = 8;

  typedef enum logic [1:0] {
    CK_DIV_A = 2'b00,
    CK_DIV_B = 2'b01,
    CK_DIV_C = 2'b10,
    CK_EXT   = 2'b11
  } clk_sel_e;

  typedef struct packed {
    logic       start;
    logic       done;
    logic [1:0] spare;
    logic       irq_en;
    logic       msb_first;
    clk_sel_e   sel;
  } mode_t;

  // Half period of the internal shift clock in system clocks.
  function automatic int unsigned half_of(input clk_sel_e sel, input int unsigned da,
                                          input int unsigned db, input int unsigned dc);
    case (sel)
      CK_DIV_A: half_of = da / 2;
      CK_DIV_B: half_of = db / 2;
      CK_DIV_C: half_of = dc / 2;
      default:  half_of = 1;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    max3 = (m > c) ? m : c;
  endfunction

  // Bit presented on SO for the current data register.
  function automatic logic out_bit(input logic [DW-1:0] d, input logic msb);
    out_bit = msb ? d[DW-1] : d[0];
  endfunction

  // Data register after one input bit has been captured.
  function automatic logic [DW-1:0] shift_in(input logic [DW-1:0] d, input logic b,
                                             input logic msb);
    shift_in = msb ? {d[DW-2:0], b} : {b, d[DW-1:1]};
  endfunction

endpackage

// File: rtl/sio8_clkgen.sv
module sio8_clkgen
  import sio8_pkg::*;
#(
  parameter int unsigned DIV_A       = 4,
  parameter int unsigned DIV_B       = 16,
  parameter int unsigned DIV_C       = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     busy,
  input  clk_sel_e sel,
  input  logic     sck_in,
  output logic     sck_out,
  output logic     sck_oe,
  output logic     fall_ev,
  output logic     rise_ev
);

  localparam int unsigned MAX_HALF = max3(DIV_A, DIV_B, DIV_C) / 2;
  localparam int unsigned CNT_W    = $clog2(MAX_HALF + 1);

  logic                   ext;
  logic [CNT_W-1:0]       cnt_q;
  logic [CNT_W-1:0]       half_m1;
  logic                   sck_q;
  logic                   int_tick;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   ext_now;

  assign ext      = (sel == CK_EXT);
  assign half_m1  = CNT_W'(half_of(sel, DIV_A, DIV_B, DIV_C) - 1);
  assign int_tick = busy && !ext && (cnt_q == half_m1);

  // Internal divider: the clock rests high and toggles every half period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (!busy || ext) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (int_tick) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // External clock synchronizer and previous-level register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], sck_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign ext_now = sync_q[SYNC_STAGES-1];

  always_comb begin
    if (!busy) begin
      fall_ev = 1'b0;
      rise_ev = 1'b0;
    end else if (ext) begin
      fall_ev = prev_q && !ext_now;
      rise_ev = !prev_q && ext_now;
    end else begin
      fall_ev = int_tick && sck_q;
      rise_ev = int_tick && !sck_q;
    end
  end

  assign sck_out = sck_q;
  assign sck_oe  = !ext;

endmodule

// File: rtl/sio8_shreg.sv
module sio8_shreg
  import sio8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          msb_first,
  input  logic          fall_ev,
  input  logic          rise_ev,
  input  logic          si,
  input  logic          load_en,
  input  logic [DW-1:0] load_data,
  output logic [DW-1:0] sdr,
  output logic          so,
  output logic          done_ev
);

  localparam int unsigned BC_W = $clog2(DW);

  logic [DW-1:0]   sdr_q;
  logic            so_q;
  logic [BC_W-1:0] bit_q;

  assign done_ev = rise_ev && (bit_q == BC_W'(DW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdr_q <= '0;
      so_q  <= 1'b1;
      bit_q <= '0;
    end else begin
      if (load_en)
        sdr_q <= load_data;
      else if (rise_ev)
        sdr_q <= shift_in(sdr_q, si, msb_first);

      if (fall_ev)
        so_q <= out_bit(sdr_q, msb_first);

      if (!busy)
        bit_q <= '0;
      else if (rise_ev)
        bit_q <= bit_q + 1'b1;
    end
  end

  assign sdr = sdr_q;
  assign so  = so_q;

endmodule

// File: rtl/sio8_ctrl.sv
module sio8_ctrl
  import sio8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          done_ev,
  output mode_t         mode,
  output logic          busy,
  output logic          data_wr_en,
  output logic          irq
);

  mode_t mode_q;
  logic  accept;

  // Writes are taken only while no transfer runs.
  assign accept     = bus_wr && !mode_q.start;
  assign data_wr_en = accept && bus_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (done_ev) begin
      mode_q.start <= 1'b0;
      mode_q.done  <= 1'b1;
    end else if (accept && !bus_addr) begin
      mode_q.start     <= bus_wdata[7];
      mode_q.spare     <= bus_wdata[5:4];
      mode_q.irq_en    <= bus_wdata[3];
      mode_q.msb_first <= bus_wdata[2];
      mode_q.sel       <= clk_sel_e'(bus_wdata[1:0]);
      if (!bus_wdata[6])
        mode_q.done <= 1'b0;
    end
  end

  assign mode = mode_q;
  assign busy = mode_q.start;
  assign irq  = mode_q.done && mode_q.irq_en;

endmodule

// File: rtl/sio8_port.sv
module sio8_port
  import sio8_pkg::*;
#(
  parameter int unsigned DIV_A       = 4,
  parameter int unsigned DIV_B       = 16,
  parameter int unsigned DIV_C       = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       sck_in,
  output logic       sck_out,
  output logic       sck_oe,
  input  logic       si,
  output logic       so,
  output logic       irq
);

  mode_t         mode_q;
  logic          busy;
  logic          data_wr_en;
  logic          fall_ev;
  logic          rise_ev;
  logic          done_ev;
  logic [DW-1:0] sdr;
  logic [1:0]    sel_w;
  logic          flag_w;

  assign sel_w  = mode_q.sel;
  assign flag_w = mode_q.done;

  sio8_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .done_ev    (done_ev),
    .mode       (mode_q),
    .busy       (busy),
    .data_wr_en (data_wr_en),
    .irq        (irq)
  );

  sio8_clkgen #(
    .DIV_A       (DIV_A),
    .DIV_B       (DIV_B),
    .DIV_C       (DIV_C),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_clkgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .sel     (mode_q.sel),
    .sck_in  (sck_in),
    .sck_out (sck_out),
    .sck_oe  (sck_oe),
    .fall_ev (fall_ev),
    .rise_ev (rise_ev)
  );

  sio8_shreg u_shreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .msb_first (mode_q.msb_first),
    .fall_ev   (fall_ev),
    .rise_ev   (rise_ev),
    .si        (si),
    .load_en   (data_wr_en),
    .load_data (bus_wdata),
    .sdr       (sdr),
    .so        (so),
    .done_ev   (done_ev)
  );

  assign bus_rdata = bus_addr ? sdr : mode_q;

endmodule

// File: rtl/sio8_port_chk.sv
module sio8_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       fall_ev,
  input logic       rise_ev,
  input logic       done_ev,
  input logic       so,
  input logic       sck_out,
  input logic [1:0] sel,
  input logic       done_flag
);

  assert_one_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_ev && rise_ev));

  assert_so_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so) |-> $past(fall_ev));

  assert_idle_sck_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck_out);

  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sel));

  assert_done_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> (done_flag && !busy));

endmodule

bind sio8_port sio8_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .fall_ev   (fall_ev),
  .rise_ev   (rise_ev),
  .done_ev   (done_ev),
  .so        (so),
  .sck_out   (sck_out),
  .sel       (sel_w),
  .done_flag (flag_w)
);

// File: tb/sio8_port_test.sv
module sio8_port_test;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sck_in = 1'b1;
  logic       sck_out;
  logic       sck_oe;
  logic       si = 1'b0;
  logic       so;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  sio8_port uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sck_in    (sck_in),
    .sck_out   (sck_out),
    .sck_oe    (sck_oe),
    .si        (si),
    .so        (so),
    .irq       (irq)
  );

  always #(CLK_P / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_sck(input logic v, output int n);
    n = 0;
    while (sck_out !== v && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic logic nth(input logic [7:0] b, input logic msb, input int i);
    return msb ? b[7-i] : b[i];
  endfunction

  // Internal-clock transfer: checks rate, duty, bit order, reception, completion.
  task automatic t_internal(input logic [1:0] sel, input logic msb, input logic [7:0] tx,
                            input logic [7:0] rx, input int div);
    logic [7:0] r;
    int n;
    bus_write(1'b1, tx);
    bus_write(1'b0, 8'h88 | {5'b0, msb, sel});
    check(sck_oe === 1'b1, "R2 sck_oe high in internal mode", sck_oe, 1);
    for (int i = 0; i < 8; i++) begin
      wait_sck(1'b0, n);
      check(so === nth(tx, msb, i), "R3 so bit on falling edge", so, nth(tx, msb, i));
      si = nth(rx, msb, i);
      wait_sck(1'b1, n);
      if (i == 0) check(n == div / 2, "R2 low half length", n, div / 2);
      if (i == 1) begin
        bus_read(1'b0, r);
        check(r[7] === 1'b1, "R6 start held during transfer", r, 8'h80);
      end
      if (i < 7) begin
        wait_sck(1'b0, n);
        if (i == 0) check(n == div / 2, "R2 high half length", n, div / 2);
        // re-align: the loop head sees sck already low
        check(so === nth(tx, msb, i + 1), "R3 so next bit", so, nth(tx, msb, i + 1));
        si = nth(rx, msb, i + 1);
        wait_sck(1'b1, n);
        i++;
        if (i == 7) break;
      end
    end
    repeat (2) @(negedge clk);
    bus_read(1'b0, r);
    check(r == (8'h48 | {5'b0, msb, sel}), "R6 R8 start cleared, flag set", r,
          8'h48 | {5'b0, msb, sel});
    check(irq === 1'b1, "R8 irq with enable", irq, 1);
    bus_read(1'b1, r);
    check(r == rx, "R4 received byte", r, rx);
    repeat (6) @(negedge clk);
    check(sck_out === 1'b1, "R9 sck idle high", sck_out, 1);
    check(so === nth(tx, msb, 7), "R9 so holds last bit", so, nth(tx, msb, 7));
  endtask

  task automatic t_flag_clear();
    logic [7:0] r;
    bus_write(1'b0, 8'h48);
    bus_read(1'b0, r);
    check(r[6] === 1'b1, "R8 writing 1 keeps flag", r[6], 1);
    bus_write(1'b0, 8'h08);
    bus_read(1'b0, r);
    check(r == 8'h08, "R8 writing 0 clears flag", r, 8'h08);
    check(irq === 1'b0, "R8 irq low after clear", irq, 0);
    bus_write(1'b0, 8'h48);
    bus_read(1'b0, r);
    check(r[6] === 1'b0, "R8 writing 1 does not set flag", r[6], 0);
    bus_write(1'b0, 8'h00);
  endtask

  // Writes in the middle of a transfer must not land.
  task automatic t_busy_writes();
    logic [7:0] r;
    int n;
    bus_write(1'b1, 8'h3C);
    bus_write(1'b0, 8'h85);            // start, MSB first, divide by 16
    for (int i = 0; i < 8; i++) begin
      wait_sck(1'b0, n);
      si = nth(8'hA6, 1'b1, i);
      if (i == 2) begin
        bus_write(1'b1, 8'h00);
        bus_write(1'b0, 8'h03);
        bus_read(1'b0, r);
        check(r == 8'h85, "R7 mode write ignored while busy", r, 8'h85);
      end
      wait_sck(1'b1, n);
    end
    repeat (2) @(negedge clk);
    bus_read(1'b1, r);
    check(r == 8'hA6, "R7 data write ignored while busy", r, 8'hA6);
    bus_read(1'b0, r);
    check(r == 8'h45, "R7 R6 mode after busy writes", r, 8'h45);
    bus_write(1'b0, 8'h01);
  endtask

  // Slow external clock, LSB first.
  task automatic t_external(input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] r;
    sck_in = 1'b1;
    bus_write(1'b1, tx);
    bus_write(1'b0, 8'h8B);            // start, irq enable, LSB first, external
    repeat (2) @(negedge clk);
    check(sck_oe === 1'b0, "R5 sck_oe low in external mode", sck_oe, 0);
    for (int i = 0; i < 8; i++) begin
      sck_in = 1'b0;
      repeat (5) @(negedge clk);
      check(so === nth(tx, 1'b0, i), "R5 R3 so follows sck_in fall", so, nth(tx, 1'b0, i));
      si = nth(rx, 1'b0, i);
      sck_in = 1'b1;
      repeat (5) @(negedge clk);
    end
    bus_read(1'b0, r);
    check(r == 8'h4B, "R5 R6 external transfer done", r, 8'h4B);
    bus_read(1'b1, r);
    check(r == rx, "R5 R4 external received byte", r, rx);
    check(sck_out === 1'b1, "R9 sck_out high in external idle", sck_out, 1);
    bus_write(1'b0, 8'h03);
  endtask

  // Fastest external clock: one system clock per level.
  task automatic t_ext_fast();
    logic [7:0] r;
    si = 1'b1;
    bus_write(1'b1, 8'h00);
    bus_write(1'b0, 8'h87);            // start, MSB first, external
    for (int i = 0; i < 7; i++) begin
      sck_in = 1'b0; @(negedge clk);
      sck_in = 1'b1; @(negedge clk);
    end
    repeat (6) @(negedge clk);
    bus_read(1'b0, r);
    check(r[7] === 1'b1, "R6 still running after 7 pulses", r[7], 1);
    sck_in = 1'b0; @(negedge clk);
    sck_in = 1'b1;
    repeat (6) @(negedge clk);
    bus_read(1'b0, r);
    check(r[7] === 1'b0, "R5 R6 done after 8 fast pulses", r[7], 0);
    bus_read(1'b1, r);
    check(r == 8'hFF, "R5 fast external received byte", r, 8'hFF);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    bus_read(1'b0, r);
    check(r == 8'h00, "R1 mode after reset", r, 0);
    check(sck_out === 1'b1, "R1 sck_out after reset", sck_out, 1);
    check(so === 1'b1, "R1 so after reset", so, 1);
    check(sck_oe === 1'b1, "R1 sck_oe after reset", sck_oe, 1);
    check(irq === 1'b0, "R1 irq after reset", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_internal(2'b00, 1'b1, 8'hB4, 8'h5A, 4);
    t_flag_clear();
    t_internal(2'b01, 1'b0, 8'h1E, 8'hC3, 16);
    bus_write(1'b0, 8'h00);
    t_internal(2'b10, 1'b1, 8'h81, 8'h7E, 64);
    bus_write(1'b0, 8'h00);
    t_busy_writes();
    t_external(8'hD2, 8'h39);
    t_ext_fast();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule